// File: doc/BRIEF.md
# Two-Channel Wiper and Stored-Setting Controller

This block keeps the digital control state of a potentiometer with two channels. Each channel owns one 8-bit wiper register, whose value picks one of 256 taps (0 to 255), and four 8-bit storage slots that stand in for nonvolatile memory. A parallel command port carries one command per cycle. Each command holds a device address, an opcode, a channel, a slot and a data byte, and it receives an accept/reject response one cycle later.

The block is built around a three-state sequencer. `ST_RECALL` is the reset state. On the first clock edge after reset it loads slot 0 of every channel into that channel's wiper and takes transition T_RECALL_DONE to `ST_IDLE`. In `ST_IDLE` a command is accepted when its address matches the strap inputs and it is not a protected stored write. An accepted stored write, either a direct slot write or a save of the wiper, takes transition T_PROG_START to `ST_PROG`. `ST_PROG` holds for a programmable number of cycles and then takes T_PROG_END back to `ST_IDLE`. Every command that arrives outside `ST_IDLE` is refused.

The storage slots are not touched by the recall reset. Only the separate clear input zeroes them, so settings survive a reset and come back through recall.

Top module: `dpot_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, every wiper is 0 and `rsp_valid` is 0. On the first rising clock edge after `rst_n` goes high, each wiper takes the value of slot 0 of its own channel and `busy` falls.
- R2: Opcode 1 (wiper write) loads `cmd_data` into the wiper of `cmd_chan` at the accepting edge. Opcode 0 (wiper read) returns that wiper in `rsp_data`.
- R3: Opcode 3 (slot write) stores `cmd_data` into slot `cmd_slot` of channel `cmd_chan`. Opcode 2 (slot read) returns that slot in `rsp_data`.
- R4: Opcode 4 copies slot `cmd_slot` of channel `cmd_chan` into that channel's wiper. Opcode 5 copies the wiper of `cmd_chan` into slot `cmd_slot` of the same channel.
- R5: Opcode 6 adds one to the wiper of `cmd_chan` and opcode 7 subtracts one. At 255 an increment leaves the wiper at 255, and at 0 a decrement leaves it at 0.
- R6: A command is accepted only when `cmd_addr` equals `strap_addr`. Otherwise it is rejected.
- R7: While `prot_n` is low, opcodes 3 and 5 are rejected and start no busy interval. Wiper writes, reads, copies into the wiper and steps are still accepted.
- R8: An accepted opcode 3 or 5 holds `busy` high for exactly PROG_CYCLES cycles, starting with the cycle after the accepting edge. Every command issued while `busy` is high is rejected.
- R9: A rejected command changes no wiper and no slot, and it returns `rsp_data` of 0.
- R10: `store_clr` high at a clock edge clears all slots to 0. The slots keep their contents across `rst_n`.
- R11: `rsp_valid` is high in exactly the cycle after each cycle in which `cmd_valid` is high. Read data shows the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset, which starts the recall |
| store_clr | input | 1 | Synchronous clear of all storage slots |
| strap_addr | input | 4 | Device address set by straps |
| prot_n | input | 1 | Low blocks writes to the storage slots |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_addr | input | 4 | Address carried by the command |
| cmd_op | input | 3 | Opcode, values 0 to 7 as listed in the requirements |
| cmd_chan | input | 1 | Channel select |
| cmd_slot | input | 2 | Storage slot select |
| cmd_data | input | 8 | Write data |
| busy | output | 1 | High in recall and during the programming interval |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Command was accepted |
| rsp_data | output | 8 | Read result, 0 unless an accepted read |
| wiper_bus | output | 16 | Wiper of channel n on bits [8n+7:8n] |

## Verification
The assertions take for granted that `strap_addr` and `prot_n` hold steady while a command is in flight. They also assume `cmd_chan` only names channels that exist. The stimulus changes straps and protection only at falling edges between commands, and it only drives channels 0 and 1. Its sweeps cover all sixteen addresses, all eight slots and wiper values in steps of 17. The bench keeps its own model of every slot and wiper.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    typedef enum logic [2:0] {
        OP_RD_WIPER = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_SLOT  = 3'd2,
        OP_WR_SLOT  = 3'd3,
        OP_LOAD     = 3'd4,
        OP_SAVE     = 3'd5,
        OP_UP       = 3'd6,
        OP_DOWN     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PROG   = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        W_HOLD = 2'd0,
        W_LOAD = 2'd1,
        W_UP   = 2'd2,
        W_DOWN = 2'd3
    } wact_e;

    typedef enum logic [1:0] {
        SRC_CMD  = 2'd0,
        SRC_SLOT = 2'd1,
        SRC_DR0  = 2'd2
    } wsrc_e;
endpackage

// File: rtl/dpot_wiper.sv
module dpot_wiper
    import dpot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wact_e        act,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (act)
                W_HOLD: q <= q;
                W_LOAD: q <= din;
                W_UP:   q <= (q == TOP) ? q : q + 1'b1;
                W_DOWN: q <= (q == '0)  ? q : q - 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dpot_store.sv
module dpot_store #(
    parameter int NCH    = 2,
    parameter int NSLOT  = 4,
    parameter int W      = 8,
    parameter int CH_W   = 1,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              we,
    input  logic [CH_W-1:0]   chan,
    input  logic [SLOT_W-1:0] slot,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic [NCH*W-1:0]  dr0_bus
);
    logic [W-1:0] mem [NCH][NSLOT];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int c = 0; c < NCH; c++)
                for (int s = 0; s < NSLOT; s++)
                    mem[c][s] <= '0;
        end else if (we) begin
            mem[chan][slot] <= wdata;
        end
    end

    assign rdata = mem[chan][slot];

    for (genvar c = 0; c < NCH; c++) begin : g_dr0
        assign dr0_bus[c*W +: W] = mem[c][0];
    end
endmodule

// File: rtl/dpot_seq.sv
module dpot_seq
    import dpot_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CH_W        = 1,
    parameter int ADDR_W      = 4,
    parameter int W           = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [2:0]        cmd_op,
    input  logic [CH_W-1:0]   cmd_chan,
    input  logic              prot_n,
    input  logic [W-1:0]      rd_val,
    output wact_e             w_act [NCH],
    output wsrc_e             w_src,
    output logic              s_we,
    output logic              s_from_wiper,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [W-1:0]      rsp_data
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

    state_e           state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    op_e              op;
    logic             hit, store_wr, accept, is_read;

    assign op       = op_e'(cmd_op);
    assign hit      = cmd_valid && (cmd_addr == strap_addr) && (state == ST_IDLE);
    assign store_wr = (op == OP_WR_SLOT) || (op == OP_SAVE);
    assign accept   = hit && !(store_wr && !prot_n);
    assign is_read  = (op == OP_RD_WIPER) || (op == OP_RD_SLOT);
    assign busy     = (state != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RECALL;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state and controls
    always_comb begin
        state_n      = state;
        cnt_n        = cnt;
        w_src        = SRC_CMD;
        s_we         = 1'b0;
        s_from_wiper = 1'b0;
        for (int c = 0; c < NCH; c++) w_act[c] = W_HOLD;
        unique case (state)
            ST_RECALL: begin
                for (int c = 0; c < NCH; c++) w_act[c] = W_LOAD;
                w_src   = SRC_DR0;
                state_n = ST_IDLE;                 // T_RECALL_DONE
            end
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_WR_WIPER: w_act[cmd_chan] = W_LOAD;
                        OP_LOAD: begin
                            w_act[cmd_chan] = W_LOAD;
                            w_src           = SRC_SLOT;
                        end
                        OP_UP:       w_act[cmd_chan] = W_UP;
                        OP_DOWN:     w_act[cmd_chan] = W_DOWN;
                        OP_WR_SLOT, OP_SAVE: begin
                            s_we         = 1'b1;
                            s_from_wiper = (op == OP_SAVE);
                            state_n      = ST_PROG;    // T_PROG_START
                            cnt_n        = CNT_LOAD;
                        end
                        OP_RD_WIPER, OP_RD_SLOT: ;
                    endcase
                end
            end
            ST_PROG: begin
                if (cnt == '0) state_n = ST_IDLE;  // T_PROG_END
                else           cnt_n   = cnt - 1'b1;
            end
            default: state_n = ST_RECALL;
        endcase
    end

    // Response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_ok    <= accept;
            rsp_data  <= (accept && is_read) ? rd_val : '0;
        end
    end
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int NSLOT       = 4,
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 4,
    parameter int PROG_CYCLES = 16,
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SLOT_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 store_clr,
    input  logic [ADDR_W-1:0]    strap_addr,
    input  logic                 prot_n,
    input  logic                 cmd_valid,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [2:0]           cmd_op,
    input  logic [CH_W-1:0]      cmd_chan,
    input  logic [SLOT_W-1:0]    cmd_slot,
    input  logic [WIDTH-1:0]     cmd_data,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic                 rsp_ok,
    output logic [WIDTH-1:0]     rsp_data,
    output logic [NCH*WIDTH-1:0] wiper_bus
);
    wact_e            w_act [NCH];
    wsrc_e            w_src;
    logic             s_we, s_from_wiper;
    logic [WIDTH-1:0] wq [NCH];
    logic [WIDTH-1:0] slot_rd, slot_wd, rd_val;
    logic [NCH*WIDTH-1:0] dr0_bus;

    assign slot_wd = s_from_wiper ? wq[cmd_chan] : cmd_data;
    assign rd_val  = (op_e'(cmd_op) == OP_RD_SLOT) ? slot_rd : wq[cmd_chan];

    dpot_store #(
        .NCH(NCH), .NSLOT(NSLOT), .W(WIDTH), .CH_W(CH_W), .SLOT_W(SLOT_W)
    ) store_i (
        .clk(clk), .clr(store_clr), .we(s_we), .chan(cmd_chan), .slot(cmd_slot),
        .wdata(slot_wd), .rdata(slot_rd), .dr0_bus(dr0_bus)
    );

    dpot_seq #(
        .NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W), .W(WIDTH), .PROG_CYCLES(PROG_CYCLES)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .strap_addr(strap_addr), .cmd_op(cmd_op), .cmd_chan(cmd_chan), .prot_n(prot_n),
        .rd_val(rd_val), .w_act(w_act), .w_src(w_src), .s_we(s_we),
        .s_from_wiper(s_from_wiper), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_data(rsp_data)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [WIDTH-1:0] din;
        always_comb begin
            unique case (w_src)
                SRC_DR0:  din = dr0_bus[c*WIDTH +: WIDTH];
                SRC_SLOT: din = slot_rd;
                default:  din = cmd_data;
            endcase
        end
        dpot_wiper #(.W(WIDTH)) wiper_i (
            .clk(clk), .rst_n(rst_n), .act(w_act[c]), .din(din), .q(wq[c])
        );
        assign wiper_bus[c*WIDTH +: WIDTH] = wq[c];
    end
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
    parameter int NCH    = 2,
    parameter int W      = 8,
    parameter int ADDR_W = 4,
    parameter int CH_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] strap_addr,
    input logic              prot_n,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [2:0]        cmd_op,
    input logic [CH_W-1:0]   cmd_chan,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic [NCH*W-1:0]  wiper_bus
);
    logic go;
    assign go = cmd_valid && !busy && (cmd_addr == strap_addr);

    a_r5_up_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd_op == 3'd6 && wiper_bus[cmd_chan*W +: W] == {W{1'b1}})
        |=> wiper_bus[$past(cmd_chan)*W +: W] == {W{1'b1}});

    a_r5_down_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd_op == 3'd7 && wiper_bus[cmd_chan*W +: W] == '0)
        |=> wiper_bus[$past(cmd_chan)*W +: W] == '0);

    a_r6_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_addr != strap_addr) |=> (rsp_valid && !rsp_ok));

    a_r9_miss_keeps_wipers: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_addr != strap_addr) |=> $stable(wiper_bus));

    a_r7_protected_store: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !prot_n && (cmd_op == 3'd3 || cmd_op == 3'd5))
        |=> (!rsp_ok && !busy));

    a_r8_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> (rsp_valid && !rsp_ok));

    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    a_r11_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
endmodule

bind dpot_ctrl dpot_ctrl_chk #(
    .NCH(NCH), .W(WIDTH), .ADDR_W(ADDR_W), .CH_W(CH_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .prot_n(prot_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_op(cmd_op), .cmd_chan(cmd_chan),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .wiper_bus(wiper_bus)
);

// File: tb/dpot_ctrl_tb.sv
module dpot_ctrl_tb_top;
    localparam int PROG = 16;
    localparam logic [3:0] STRAP = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n, store_clr, prot_n, cmd_valid;
    logic [3:0] strap_addr, cmd_addr;
    logic [2:0] cmd_op;
    logic       cmd_chan;
    logic [1:0] cmd_slot;
    logic [7:0] cmd_data;
    logic       busy, rsp_valid, rsp_ok;
    logic [7:0] rsp_data;
    logic [15:0] wiper_bus;

    int checks = 0, fails = 0;
    bit done = 0;
    logic       r_valid, r_ok;
    logic [7:0] r_data;
    int st [2][4];
    int wp [2];

    always #10 clk = ~clk;

    dpot_ctrl #(.PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .store_clr(store_clr), .strap_addr(strap_addr),
        .prot_n(prot_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_slot(cmd_slot), .cmd_data(cmd_data), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data), .wiper_bus(wiper_bus)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int ch, input int slot, input int data,
                         input logic [3:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_chan = ch[0];
        cmd_slot = 2'(slot); cmd_data = 8'(data); cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        r_valid = rsp_valid; r_ok = rsp_ok; r_data = rsp_data;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    function automatic int wv(input int ch);
        return int'(wiper_bus[ch*8 +: 8]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; store_clr = 1; prot_n = 1; cmd_valid = 0; strap_addr = STRAP;
        cmd_addr = 0; cmd_op = 0; cmd_chan = 0; cmd_slot = 0; cmd_data = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1, "R1 busy in reset", busy, 1);
        chk(wiper_bus == 0, "R1 wiper in reset", wiper_bus, 0);
        chk(rsp_valid == 0, "R1 rsp_valid in reset", rsp_valid, 0);
        store_clr = 0; rst_n = 1;
        @(negedge clk);
        chk(busy == 0, "R1 busy after recall", busy, 0);
        for (int c = 0; c < 2; c++) begin st[c] = '{0, 0, 0, 0}; wp[c] = 0; end

        // R3 slot writes, R8 busy length on the first one
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++) begin
                int v = ((c * 4 + s) * 29 + 7) & 255;
                issue(3, c, s, v, STRAP);
                chk(r_valid && r_ok, "R3 slot write accepted", r_ok, 1);
                st[c][s] = v;
                if (c == 0 && s == 0) begin
                    int n = 0;
                    while (busy && n < 1000) begin n++; @(negedge clk); end
                    chk(n == PROG, "R8 busy length", n, PROG);
                end
                wait_idle();
            end
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++) begin
                issue(2, c, s, 0, STRAP);
                chk(r_ok && int'(r_data) == st[c][s], "R3 slot read", r_data, st[c][s]);
            end

        // R2 wiper write/read sweep, R11 read shows old value
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v += 17) begin
                issue(1, c, 0, v, STRAP);
                chk(wv(c) == v, "R2 wiper write", wv(c), v);
                wp[c] = v;
                issue(0, c, 0, 0, STRAP);
                chk(r_valid && int'(r_data) == v, "R2 wiper read", r_data, v);
            end
        issue(0, 1, 0, 0, STRAP);
        @(negedge clk);
        chk(rsp_valid == 0, "R11 no response without command", rsp_valid, 0);

        // R4 copy slot -> wiper
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++) begin
                issue(4, c, s, 0, STRAP);
                chk(wv(c) == st[c][s], "R4 slot to wiper", wv(c), st[c][s]);
                wp[c] = st[c][s];
            end
        // R4 copy wiper -> slot
        issue(1, 1, 0, 8'h5C, STRAP);
        issue(5, 1, 2, 0, STRAP);
        chk(r_ok && busy, "R4 save starts programming", busy, 1);
        wait_idle();
        st[1][2] = 8'h5C;
        issue(2, 1, 2, 0, STRAP);
        chk(int'(r_data) == 8'h5C, "R4 wiper to slot", r_data, 8'h5C);

        // R5 steps and saturation
        issue(1, 0, 0, 254, STRAP);
        issue(6, 0, 0, 0, STRAP); chk(wv(0) == 255, "R5 up to 255", wv(0), 255);
        issue(6, 0, 0, 0, STRAP); chk(wv(0) == 255, "R5 up saturates", wv(0), 255);
        issue(1, 0, 0, 1, STRAP);
        issue(7, 0, 0, 0, STRAP); chk(wv(0) == 0, "R5 down to 0", wv(0), 0);
        issue(7, 0, 0, 0, STRAP); chk(wv(0) == 0, "R5 down saturates", wv(0), 0);
        issue(1, 1, 0, 100, STRAP);
        issue(6, 1, 0, 0, STRAP); chk(wv(1) == 101, "R5 up mid", wv(1), 101);
        issue(7, 1, 0, 0, STRAP); issue(7, 1, 0, 0, STRAP);
        chk(wv(1) == 99, "R5 down mid", wv(1), 99);

        // R6 address sweep, R9 miss changes nothing
        for (int a = 0; a < 16; a++) begin
            issue(0, 1, 0, 0, 4'(a));
            chk(r_valid && (r_ok == (a == STRAP)), "R6 address match", r_ok, a == STRAP);
        end
        issue(1, 1, 0, 33, 4'h3);
        chk(wv(1) == 99 && r_data == 0, "R9 miss keeps wiper", wv(1), 99);
        issue(3, 0, 1, 77, 4'h3);
        chk(!busy, "R9 miss starts no programming", busy, 0);
        issue(2, 0, 1, 0, STRAP);
        chk(int'(r_data) == st[0][1], "R9 miss keeps slot", r_data, st[0][1]);

        // R7 protection
        @(negedge clk); prot_n = 0;
        issue(3, 0, 3, 200, STRAP);
        chk(!r_ok && !busy, "R7 slot write blocked", r_ok, 0);
        issue(5, 0, 3, 0, STRAP);
        chk(!r_ok && !busy, "R7 save blocked", r_ok, 0);
        issue(2, 0, 3, 0, STRAP);
        chk(int'(r_data) == st[0][3], "R7 slot unchanged", r_data, st[0][3]);
        issue(1, 0, 0, 150, STRAP);
        chk(r_ok && wv(0) == 150, "R7 wiper write allowed", wv(0), 150);
        @(negedge clk); prot_n = 1;

        // R8 commands refused while busy
        issue(3, 1, 3, 222, STRAP);
        st[1][3] = 222;
        issue(1, 0, 0, 9, STRAP);
        chk(!r_ok && wv(0) == 150, "R8 busy refuses wiper write", wv(0), 150);
        issue(0, 0, 0, 0, STRAP);
        chk(!r_ok && r_data == 0, "R8 busy refuses read", r_data, 0);
        wait_idle();
        issue(2, 1, 3, 0, STRAP);
        chk(int'(r_data) == 222, "R8 write completed", r_data, 222);

        // R1 recall on reset, R10 slots survive reset
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk(wiper_bus == 0 && busy, "R1 reset clears wipers", wiper_bus, 0);
        rst_n = 1;
        @(negedge clk);
        chk(wv(0) == st[0][0], "R1 recall ch0", wv(0), st[0][0]);
        chk(wv(1) == st[1][0], "R1 recall ch1", wv(1), st[1][0]);
        issue(2, 1, 3, 0, STRAP);
        chk(int'(r_data) == 222, "R10 slot kept across reset", r_data, 222);

        // R10 clear
        @(negedge clk); store_clr = 1;
        @(negedge clk); store_clr = 0;
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++) begin
                issue(2, c, s, 0, STRAP);
                chk(r_ok && r_data == 0, "R10 clear", r_data, 0);
            end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule